// File: doc/BRIEF.md
# Relocatable Local-Bus SRAM

This block is a tightly coupled on-chip memory that sits on a processor's local bus. It answers a read or write whenever the bus address falls inside a window whose location is set by a base register. The window can be moved at run time to any 32 KB-aligned address in the 32-bit space. A hit is answered one clock after the request, with no wait states.

The base register holds the window base, an enable (valid) bit and reserved bits. The processor can only write it. A debug port can both read and write it. Accesses can be bytes, halfwords or words on big-endian byte lanes.

When the request is an instruction fetch, the response carries an override flag. The fetch unit uses it to discard data that a cache returned in parallel. Every data response from the block is marked non-cacheable.

Top module: `lbus_sram`

## Requirements
- R1: A request that hits the window gets its response (`rsp_valid_o` high) in the clock cycle right after the one in which it was presented. No wait states are ever inserted.
- R2: A request hits only when the valid bit is set and `addr_i[31:15]` equals the programmed base field. A request that misses produces no response: `rsp_valid_o` stays low in the following cycle.
- R3: The base register layout is: bits 31:15 hold the window base, bit 0 is the valid bit, and bits 14:1 are reserved. Writes to reserved bits are ignored, and those bits read as zero on `dbg_bar_rdata_o`.
- R4: Reset clears the valid bit, which disables the memory. The base field keeps its value through reset.
- R5: The processor path (`cpu_bar_we_i`) can only write the register. The debug path can write it and always reads it on `dbg_bar_rdata_o`. When both write in the same cycle, the debug value is taken. Without a write the register holds.
- R6: The size encoding is 00 byte, 01 halfword, 10 word. Byte lanes are big-endian: the byte at offset k of a word travels on bits [31-8k -: 8] of `wdata_i` and `rdata_o`. A write changes only the bytes it addresses. A read returns the whole aligned word.
- R7: The following accesses are misaligned: a halfword at an odd address, a word whose `addr_i[1:0]` is not zero, and size 11. A misaligned access that hits answers with `rsp_err_o` high and `rdata_o` zero, and it writes nothing.
- R8: An instruction fetch (`fetch_i` high, `we_i` low) that hits without error raises `override_o` in its response cycle. Any other response leaves `override_o` low.
- R9: Every hit response without error raises `nocache_o`. Error responses and idle cycles leave it low.
- R10: The storage holds 2^MEM_LOG2 bytes and is indexed by `addr_i[MEM_LOG2-1:0]`. With the defaults (4 KB of storage in a 32 KB window), storage repeats every 4 KB inside the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus request strobe |
| we_i | input | 1 | Write (1) or read (0) |
| fetch_i | input | 1 | Request is an instruction fetch |
| size_i | input | 2 | Access size: 00 byte, 01 halfword, 10 word |
| addr_i | input | 32 | Byte address |
| wdata_i | input | 32 | Write data on big-endian lanes |
| rsp_valid_o | output | 1 | Response for the previous cycle's hit |
| rsp_err_o | output | 1 | Response is a misalignment error |
| rdata_o | output | 32 | Read data (zero for writes and errors) |
| override_o | output | 1 | Discard parallel cache data for this fetch |
| nocache_o | output | 1 | Response data must not be cached |
| cpu_bar_we_i | input | 1 | Processor write to the base register |
| cpu_bar_wdata_i | input | 32 | Processor write value |
| dbg_bar_we_i | input | 1 | Debug write to the base register |
| dbg_bar_wdata_i | input | 32 | Debug write value |
| dbg_bar_rdata_o | output | 32 | Debug readback of the base register |

## Verification
The access patterns mix sizes and byte offsets over one shared word. Only correct lane enables and big-endian placement leave the expected merged word; swapped or widened lanes corrupt neighbouring bytes. Misaligned halfwords and words are each followed by a read of the same word, which shows both the error response and that nothing was written.

Reads at a mirrored offset, above the window and under a moved base separate the upper-address compare from the storage index. A register sequence covers the following: simultaneous processor and debug writes, reserved-bit patterns, and a mid-run reset that must clear only the valid bit. Fetches and plain reads to the same word separate the override flag from the non-cacheable flag.

// File: rtl/lbus_sram_pkg.sv
package lbus_sram_pkg;

  localparam int unsigned LANES  = 4;
  localparam int unsigned BUS_W  = 8 * LANES;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  // big-endian: offset 0 is lane 3 (bits 31:24)
  function automatic logic [LANES-1:0] lane_mask(acc_size_e sz, logic [1:0] off);
    logic [LANES-1:0] m;
    case (sz)
      SZ_BYTE: m = 4'b1000 >> off;
      SZ_HALF: m = off[1] ? 4'b0011 : 4'b1100;
      SZ_WORD: m = 4'b1111;
      default: m = 4'b0000;
    endcase
    return m;
  endfunction

  function automatic logic is_misaligned(acc_size_e sz, logic [1:0] off);
    logic bad;
    case (sz)
      SZ_BYTE: bad = 1'b0;
      SZ_HALF: bad = off[0];
      SZ_WORD: bad = |off;
      default: bad = 1'b1;
    endcase
    return bad;
  endfunction

endpackage

// File: rtl/lbus_sram_bar.sv
module lbus_sram_bar #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned WIN_LOG2 = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_wdata_i,
  input  logic              dbg_we_i,
  input  logic [ADDR_W-1:0] dbg_wdata_i,
  output logic [ADDR_W-WIN_LOG2-1:0] base_o,
  output logic              valid_o,
  output logic [ADDR_W-1:0] rdata_o
);

  localparam int unsigned BASE_W = ADDR_W - WIN_LOG2;
  localparam int unsigned RSVD_W = WIN_LOG2 - 1;

  logic [BASE_W-1:0] base_q;
  logic              valid_q;
  logic [ADDR_W-1:0] wsel;
  logic              wr;

  // debug path takes priority over the processor path
  assign wr   = dbg_we_i | cpu_we_i;
  assign wsel = dbg_we_i ? dbg_wdata_i : cpu_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  valid_q <= 1'b0;
    else if (wr)  valid_q <= wsel[0];
  end

  // base survives reset
  always_ff @(posedge clk_i) begin
    if (wr) base_q <= wsel[ADDR_W-1:WIN_LOG2];
  end

  assign base_o  = base_q;
  assign valid_o = valid_q;
  assign rdata_o = {base_q, {RSVD_W{1'b0}}, valid_q};

  AST_BAR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_we_i && !dbg_we_i |=> $stable(base_q) && $stable(valid_q)); // R5

endmodule

// File: rtl/lbus_sram_decode.sv
module lbus_sram_decode
  import lbus_sram_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned WIN_LOG2 = 15
) (
  input  logic              req_i,
  input  logic              we_i,
  input  acc_size_e         size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-WIN_LOG2-1:0] base_i,
  input  logic              valid_i,
  output logic              hit_o,
  output logic              err_o,
  output logic [LANES-1:0]  be_o
);

  logic in_win;
  logic bad;

  assign in_win = valid_i && (addr_i[ADDR_W-1:WIN_LOG2] == base_i);
  assign hit_o  = req_i && in_win;
  assign bad    = is_misaligned(size_i, addr_i[1:0]);
  assign err_o  = hit_o && bad;
  assign be_o   = (hit_o && we_i && !bad) ? lane_mask(size_i, addr_i[1:0]) : '0;

endmodule

// File: rtl/lbus_sram_array.sv
module lbus_sram_array
  import lbus_sram_pkg::*;
#(
  parameter int unsigned MEM_LOG2 = 12
) (
  input  logic                  clk_i,
  input  logic [MEM_LOG2-3:0]   idx_i,
  input  logic [LANES-1:0]      be_i,
  input  logic [BUS_W-1:0]      wdata_i,
  output logic [BUS_W-1:0]      rdata_o
);

  localparam int unsigned DEPTH = 1 << (MEM_LOG2 - 2);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] mem [DEPTH];
    logic [7:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (be_i[l]) mem[idx_i] <= wdata_i[8*l +: 8];
      rd_q <= mem[idx_i];
    end

    assign rdata_o[8*l +: 8] = rd_q;
  end

endmodule

// File: rtl/lbus_sram.sv
module lbus_sram
  import lbus_sram_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned WIN_LOG2 = 15,
  parameter int unsigned MEM_LOG2 = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              fetch_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic              rsp_valid_o,
  output logic              rsp_err_o,
  output logic [31:0]       rdata_o,
  output logic              override_o,
  output logic              nocache_o,
  input  logic              cpu_bar_we_i,
  input  logic [ADDR_W-1:0] cpu_bar_wdata_i,
  input  logic              dbg_bar_we_i,
  input  logic [ADDR_W-1:0] dbg_bar_wdata_i,
  output logic [ADDR_W-1:0] dbg_bar_rdata_o
);

  localparam int unsigned BASE_W = ADDR_W - WIN_LOG2;

  logic [BASE_W-1:0] base;
  logic              bar_valid;
  logic              hit, err;
  logic [LANES-1:0]  be;
  logic [BUS_W-1:0]  arr_rdata;
  acc_size_e         size;

  logic rsp_valid_q, rsp_err_q, rsp_we_q, rsp_fetch_q;

  assign size = acc_size_e'(size_i);

  lbus_sram_bar #(.ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2)) u_bar (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cpu_we_i   (cpu_bar_we_i),
    .cpu_wdata_i(cpu_bar_wdata_i),
    .dbg_we_i   (dbg_bar_we_i),
    .dbg_wdata_i(dbg_bar_wdata_i),
    .base_o     (base),
    .valid_o    (bar_valid),
    .rdata_o    (dbg_bar_rdata_o)
  );

  lbus_sram_decode #(.ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2)) u_dec (
    .req_i  (req_i),
    .we_i   (we_i),
    .size_i (size),
    .addr_i (addr_i),
    .base_i (base),
    .valid_i(bar_valid),
    .hit_o  (hit),
    .err_o  (err),
    .be_o   (be)
  );

  lbus_sram_array #(.MEM_LOG2(MEM_LOG2)) u_arr (
    .clk_i  (clk_i),
    .idx_i  (addr_i[MEM_LOG2-1:2]),
    .be_i   (be),
    .wdata_i(wdata_i),
    .rdata_o(arr_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_we_q    <= 1'b0;
      rsp_fetch_q <= 1'b0;
    end else begin
      rsp_valid_q <= hit;
      rsp_err_q   <= err;
      rsp_we_q    <= we_i;
      rsp_fetch_q <= fetch_i;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_err_o   = rsp_valid_q && rsp_err_q;
  assign nocache_o   = rsp_valid_q && !rsp_err_q;
  assign override_o  = rsp_valid_q && !rsp_err_q && rsp_fetch_q && !rsp_we_q;
  assign rdata_o     = (rsp_valid_q && !rsp_err_q && !rsp_we_q) ? arr_rdata : '0;

  AST_HIT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> rsp_valid_o); // R1

  AST_MISS_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !hit |=> !rsp_valid_o); // R2

  AST_FETCH_OVERRIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit && !err && fetch_i && !we_i |=> override_o && nocache_o); // R8

  AST_ERR_NO_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err |-> be == '0); // R7

endmodule

// File: tb/lbus_sram_bench.sv
module lbus_sram_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, fetch = 1'b0;
  logic [1:0]  size = 2'b00;
  logic [31:0] addr = '0, wdata = '0;
  logic        rsp_valid, rsp_err, override, nocache;
  logic [31:0] rdata;
  logic        cpu_we = 1'b0, dbg_we = 1'b0;
  logic [31:0] cpu_wd = '0, dbg_wd = '0, dbg_rd;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  lbus_sram u_lbus_sram (
    .clk_i(clk), .rst_ni(rst_n),
    .req_i(req), .we_i(we), .fetch_i(fetch), .size_i(size),
    .addr_i(addr), .wdata_i(wdata),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rdata_o(rdata),
    .override_o(override), .nocache_o(nocache),
    .cpu_bar_we_i(cpu_we), .cpu_bar_wdata_i(cpu_wd),
    .dbg_bar_we_i(dbg_we), .dbg_bar_wdata_i(dbg_wd),
    .dbg_bar_rdata_o(dbg_rd)
  );

  // reference model
  logic [16:0] m_base;
  logic        m_valid = 1'b0;
  logic [7:0]  mb [4096];

  typedef struct {
    logic        v;
    logic        e;
    logic        rd;
    logic [31:0] d;
    logic        ov;
    string       tag;
  } exp_t;

  exp_t scb [$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: response registered at the edge after the request
  always @(posedge clk) begin
    #2;
    if (scb.size() > 0) begin
      exp_t x;
      x = scb.pop_front();
      chk({x.tag, " R1/R2 valid"}, {31'b0, rsp_valid}, {31'b0, x.v});
      if (x.v) begin
        chk({x.tag, " R7 err"}, {31'b0, rsp_err}, {31'b0, x.e});
        chk({x.tag, " R8 override"}, {31'b0, override}, {31'b0, x.ov});
        chk({x.tag, " R9 nocache"}, {31'b0, nocache}, {31'b0, !x.e});
        if (x.rd || x.e) chk({x.tag, " R6 rdata"}, rdata, x.d);
      end
    end
  end

  task automatic bus(input logic w, input logic f, input logic [1:0] sz,
                     input logic [31:0] a, input logic [31:0] wd, input string tag);
    exp_t x;
    logic hit, bad;
    logic [11:0] ab;
    @(negedge clk);
    req = 1'b1; we = w; fetch = f; size = sz; addr = a; wdata = wd;
    hit = m_valid && (a[31:15] == m_base);
    bad = (sz == 2'b11) || (sz == 2'b01 && a[0]) || (sz == 2'b10 && a[1:0] != 2'b00);
    ab  = {a[11:2], 2'b00};
    x.v = hit; x.e = hit && bad; x.rd = !w; x.tag = tag;
    x.ov = hit && !bad && f && !w;
    x.d = 32'h0;
    if (hit && !bad) begin
      if (w) begin
        for (int k = 0; k < 4; k++) begin
          bit take;
          take = (sz == 2'b10) || (sz == 2'b00 && k == a[1:0]) ||
                 (sz == 2'b01 && k[1] == a[1]);
          if (take) mb[{a[11:2], 2'(k)}] = wd[31-8*k -: 8];
        end
      end else begin
        x.d = {mb[ab], mb[ab+12'd1], mb[ab+12'd2], mb[ab+12'd3]};
      end
    end
    scb.push_back(x);
    @(posedge clk);
    #1 req = 1'b0; we = 1'b0; fetch = 1'b0;
  endtask

  task automatic bar_wr(input logic c, input logic [31:0] cv,
                        input logic d, input logic [31:0] dv);
    @(negedge clk);
    cpu_we = c; cpu_wd = cv; dbg_we = d; dbg_wd = dv;
    @(negedge clk);
    cpu_we = 1'b0; dbg_we = 1'b0;
    if (d)      begin m_base = dv[31:15]; m_valid = dv[0]; end
    else if (c) begin m_base = cv[31:15]; m_valid = cv[0]; end
  endtask

  task automatic bar_rd(input string tag);
    @(negedge clk);
    chk(tag, dbg_rd, {m_base, 14'b0, m_valid});
  endtask

  localparam logic [31:0] B0 = 32'h2000_8000;
  localparam logic [31:0] B1 = 32'h7FFF_0000;

  initial begin
    repeat (3) @(negedge clk);
    chk("R4 reset valid bit and reserved zero", {17'b0, dbg_rd[14:0]}, 32'h0);
    chk("R1 no response in reset", {31'b0, rsp_valid}, 32'h0);
    rst_n = 1'b1;

    // disabled: no response
    bus(1'b0, 1'b0, 2'b10, 32'h0000_0010, 32'h0, "R4 disabled access");

    // processor write, reserved bits set
    bar_wr(1'b1, 32'hFFFF_FFFF, 1'b0, 32'h0);
    bar_rd("R3 reserved ignored on cpu write");
    // simultaneous: debug wins
    bar_wr(1'b1, B1 | 32'h1, 1'b1, B0 | 32'h0000_7FFF);
    bar_rd("R5 debug wins simultaneous write");
    chk("R3 reserved read zero", dbg_rd, B0 | 32'h1);

    bus(1'b1, 1'b0, 2'b10, B0 + 32'h10, 32'h1122_3344, "R6 word write");
    bus(1'b0, 1'b0, 2'b10, B0 + 32'h10, 32'h0, "R6 word read");
    bus(1'b1, 1'b0, 2'b00, B0 + 32'h11, 32'h00AA_0000, "R6 byte write off1");
    bus(1'b0, 1'b0, 2'b10, B0 + 32'h10, 32'h0, "R6 read after byte");
    bus(1'b1, 1'b0, 2'b01, B0 + 32'h12, 32'hFFFF_BEEF, "R6 half write off2");
    bus(1'b0, 1'b0, 2'b01, B0 + 32'h10, 32'h0, "R6 half read whole word");
    bus(1'b1, 1'b0, 2'b00, B0 + 32'h13, 32'h5555_5577, "R6 byte write off3");
    bus(1'b0, 1'b0, 2'b00, B0 + 32'h10, 32'h0, "R6 read after byte3");

    // misaligned
    bus(1'b1, 1'b0, 2'b01, B0 + 32'h13, 32'hDEAD_DEAD, "R7 odd half write");
    bus(1'b1, 1'b0, 2'b10, B0 + 32'h12, 32'hDEAD_DEAD, "R7 word off2 write");
    bus(1'b1, 1'b0, 2'b11, B0 + 32'h10, 32'hDEAD_DEAD, "R7 size11 write");
    bus(1'b0, 1'b0, 2'b10, B0 + 32'h11, 32'h0, "R7 misaligned read");
    bus(1'b0, 1'b0, 2'b10, B0 + 32'h10, 32'h0, "R7 word unchanged");

    // fetch override
    bus(1'b0, 1'b1, 2'b10, B0 + 32'h10, 32'h0, "R8 fetch hit");
    bus(1'b0, 1'b1, 2'b01, B0 + 32'h11, 32'h0, "R8 fetch misaligned");
    bus(1'b0, 1'b1, 2'b10, B0 + 32'h8010, 32'h0, "R8 fetch miss");

    // window edges, mirroring
    bus(1'b0, 1'b0, 2'b10, B0 - 32'h4, 32'h0, "R2 below window");
    bus(1'b0, 1'b0, 2'b10, B0 + 32'h8000, 32'h0, "R2 above window");
    bus(1'b1, 1'b0, 2'b10, B0 + 32'h7FFC, 32'hCAFE_F00D, "R2 top word write");
    bus(1'b0, 1'b0, 2'b10, B0 + 32'h1010, 32'h0, "R10 mirror read");
    bus(1'b0, 1'b0, 2'b10, B0 + 32'h0FFC, 32'h0, "R10 mirror of top word");

    // relocate through processor path
    bar_wr(1'b1, B1 | 32'h1, 1'b0, 32'h0);
    bar_rd("R5 cpu relocation");
    bus(1'b0, 1'b0, 2'b10, B0 + 32'h10, 32'h0, "R2 old window misses");
    bus(1'b0, 1'b0, 2'b10, B1 + 32'h10, 32'h0, "R2 new window hits");

    // reset mid-run keeps base, clears valid
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    m_valid = 1'b0;
    bar_rd("R4 base kept valid cleared");
    bus(1'b0, 1'b0, 2'b10, B1 + 32'h10, 32'h0, "R4 no hit after reset");
    bar_wr(1'b0, 32'h0, 1'b1, B1 | 32'h1);
    bus(1'b0, 1'b1, 2'b10, B1 + 32'h10, 32'h0, "R4 data after re-enable");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule